// File: doc/BRIEF.md
# Countdown Watchdog Timer with Register Access

This block is a watchdog timer that software sees as two 32-bit registers on a simple write-strobe, combinational-read register port. One register holds a 16-bit timeout in ticks. The other is a control word holding these bits:

- a run enable;
- a sticky expiry flag, cleared by writing 1 to it;
- a bit that chooses between a reset request and a shutdown request on expiry;
- a read-only view of an external hardware-disable input;
- a self-clearing restart command.

A prescaler divides the clock into ticks. Its division ratio is picked by a 2-bit select input from four parameter values. The countdown loses one count per tick while the timer runs. Software keeps the system alive by writing the restart command often enough. If it stops doing so, the count runs out. The timer then stops itself, raises the expiry flag and pulses exactly one of its two request outputs for one clock.

The register offsets are fixed: control at 0, timeout at 4. The actual reset and shutdown circuitry sits outside this block.

Top module: `wdt_core`

## Requirements
- R1: After a synchronous active-low reset, both registers read 0 and both request outputs are low.
- R2: The control word at offset 0 reads as follows: bit 0 is run, bit 1 is fired, bit 2 is shutdown-select and bit 3 mirrors `hw_disable`. Bit 7 (restart) and every other bit read 0.
- R3: The timeout word at offset 4 stores write bits 15:0 and reads them back with bits 31:16 at 0. Accesses to any other offset read 0 and change nothing.
- R4: A tick occurs every D clocks while running, where D is DIV_0, DIV_1, DIV_2 or DIV_3 for `tick_sel` 0, 1, 2 or 3. After a restart, the first tick comes a full D clocks later.
- R5: With timeout N loaded, expiry happens on tick max(N,1). The request pulse is visible N·D clocks after the loading write edge, and D clocks after it for N=0.
- R6: Writing control with bit 7 set reloads the countdown from the timeout register and restarts the prescaler.
- R7: A control write with bit 0 at 0 pauses the countdown and raises no request. A later write taking run from 0 to 1 reloads the countdown and restarts the prescaler.
- R8: On expiry, run clears and fired sets. Exactly one output pulses for one clock: `reset_req` when bit 2 is 0, `shutdown_req` when bit 2 is 1.
- R9: Writing 1 to control bit 1 clears fired. Writing 0 to it leaves fired unchanged.
- R10: While `hw_disable` is high, writes of run are ignored and a running timer stops. No request is raised.
- R11: When a control write without bit 7 set meets an expiry edge, the expiry wins: run ends at 0 and fired ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| hw_disable | input | 1 | Hardware disable; holds the timer stopped |
| tick_sel | input | 2 | Prescaler ratio select |
| reset_req | output | 1 | One-clock reset request on expiry |
| shutdown_req | output | 1 | One-clock shutdown request on expiry |

## Verification
The assertions check the following on every cycle:
- request pulses never overlap and never last two clocks;
- a request always coincides with fired set and run cleared;
- fired stays set until a write-one clears it;
- the disable input forces run low;
- ticks never come back to back;
- a restart zeroes the prescaler and loads the timeout;
- the countdown holds between ticks.

Only the bench scenarios can show the exact expiry distances for each prescaler ratio and for a timeout of zero. They also cover:
- a restart command pushing expiry out;
- pause and resume reloading the count;
- the collision where a control write lands on the expiry edge.

// File: rtl/wdt_pkg.sv
// Package: wdt_pkg
// Shared field positions and widths for the watchdog core.
// Assumes a 32-bit register word and a 16-bit timeout.
package wdt_pkg;
    localparam int unsigned REG_W      = 32;
    localparam int unsigned TMO_W      = 16;
    localparam int unsigned BIT_RUN    = 0;
    localparam int unsigned BIT_FIRED  = 1;
    localparam int unsigned BIT_SDSEL  = 2;
    localparam int unsigned BIT_HWDIS  = 3;
    localparam int unsigned BIT_RELOAD = 7;

    // Writable control state kept in flops.
    typedef struct packed {
        logic sd_sel;
        logic fired;
        logic run;
    } ctrl_state_t;
endpackage

// File: rtl/wdt_regs.sv
// Module: wdt_regs
// Control and timeout registers of the watchdog.
// Decodes writes and produces the restart strobe for the prescaler and
// the countdown. Expiry from the countdown overrides software writes to
// run and fired. Assumes one write per strobe cycle.
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int unsigned ADDR_W    = 3,
    parameter int unsigned CTRL_OFF  = 0,
    parameter int unsigned COUNT_OFF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              hw_disable,
    input  logic              expire,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              run,
    output logic              fired,
    output logic              sd_sel,
    output logic              restart,
    output logic [TMO_W-1:0]  timeout
);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(CTRL_OFF);
    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(COUNT_OFF);

    ctrl_state_t st_q;
    logic [TMO_W-1:0] tmo_q;
    logic ctrl_wr;
    logic count_wr;
    logic unused_wdata_bits;

    // Decode which register a write targets.
    assign ctrl_wr  = reg_wr && (reg_addr == A_CTRL);
    assign count_wr = reg_wr && (reg_addr == A_COUNT);
    assign unused_wdata_bits = ^{reg_wdata[REG_W-1:BIT_RELOAD+1],
                                 reg_wdata[BIT_RELOAD-1:BIT_SDSEL+1]};

    // Restart on explicit reload or on a run rising edge that is allowed.
    assign restart = ctrl_wr && (reg_wdata[BIT_RELOAD] ||
                     (reg_wdata[BIT_RUN] && !st_q.run && !hw_disable));

    // Control state update: expiry beats software, disable beats run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            if (ctrl_wr) begin
                st_q.run    <= reg_wdata[BIT_RUN] && !hw_disable;
                st_q.sd_sel <= reg_wdata[BIT_SDSEL];
                if (reg_wdata[BIT_FIRED]) begin
                    st_q.fired <= 1'b0;
                end
            end else if (hw_disable) begin
                st_q.run <= 1'b0;
            end
            if (expire) begin
                st_q.run   <= 1'b0;
                st_q.fired <= 1'b1;
            end
        end
    end

    // Timeout register holds the low 16 bits of a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmo_q <= '0;
        end else if (count_wr) begin
            tmo_q <= reg_wdata[TMO_W-1:0];
        end
    end

    // Read multiplexer; reload and reserved bits read zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CTRL) begin
            reg_rdata[BIT_RUN]   = st_q.run;
            reg_rdata[BIT_FIRED] = st_q.fired;
            reg_rdata[BIT_SDSEL] = st_q.sd_sel;
            reg_rdata[BIT_HWDIS] = hw_disable;
        end else if (reg_addr == A_COUNT) begin
            reg_rdata[TMO_W-1:0] = tmo_q;
        end
    end

    assign run     = st_q.run;
    assign fired   = st_q.fired;
    assign sd_sel  = st_q.sd_sel;
    assign timeout = tmo_q;

    AST_DISABLE_STOPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        hw_disable |=> !run); // R10
    AST_FIRED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fired && !(reg_wr && reg_addr == A_CTRL && reg_wdata[BIT_FIRED])) |=> fired); // R9
endmodule

// File: rtl/wdt_prescaler.sv
// Module: wdt_prescaler
// Divides the clock into ticks with one of four parameter ratios.
// Restarts from zero on restart or while stopped, so the first tick is
// a full period away. Assumes every ratio is at least 2.
module wdt_prescaler #(
    parameter int unsigned DIV_0 = 2,
    parameter int unsigned DIV_1 = 3,
    parameter int unsigned DIV_2 = 5,
    parameter int unsigned DIV_3 = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int unsigned MAX_A   = (DIV_0 > DIV_1) ? DIV_0 : DIV_1;
    localparam int unsigned MAX_B   = (DIV_2 > DIV_3) ? DIV_2 : DIV_3;
    localparam int unsigned MAX_DIV = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned PW      = $clog2(MAX_DIV + 1);

    function automatic int unsigned div_at(input int unsigned idx);
        case (idx)
            0:       return DIV_0;
            1:       return DIV_1;
            2:       return DIV_2;
            default: return DIV_3;
        endcase
    endfunction

    logic [PW-1:0] last_tab [4];
    logic [PW-1:0] last;
    logic [PW-1:0] pcnt;

    // Terminal count for each ratio.
    for (genvar g = 0; g < 4; g++) begin : g_div
        assign last_tab[g] = PW'(div_at(g) - 1);
    end

    assign last = last_tab[sel];
    assign tick = run && !restart && (pcnt >= last);

    // Phase counter, cleared on restart, stop or wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (restart || !run || (pcnt >= last)) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + PW'(1);
        end
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R4
    AST_RESTART_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (pcnt == '0)); // R6
endmodule

// File: rtl/wdt_countdown.sv
// Module: wdt_countdown
// Tick-driven down-counter and expiry request generator.
// Loads on restart, counts down on tick. The tick that finds the count at
// 1 or 0 expires the timer. Assumes tick and load never coincide.
module wdt_countdown
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMO_W-1:0] load_val,
    input  logic             tick,
    input  logic             sd_sel,
    output logic             expire,
    output logic             reset_req,
    output logic             shutdown_req
);
    logic [TMO_W-1:0] cnt;

    assign expire = tick && !load && (cnt <= TMO_W'(1));

    // Count register: load, decrement or park at zero on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (expire) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt - TMO_W'(1);
        end
    end

    // One-clock request pulse steered by the shutdown select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_req    <= 1'b0;
            shutdown_req <= 1'b0;
        end else begin
            reset_req    <= expire && !sd_sel;
            shutdown_req <= expire && sd_sel;
        end
    end

    AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(cnt)); // R7
    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val))); // R6
    AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reset_req, shutdown_req})); // R8
    AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req || shutdown_req) |=> !(reset_req || shutdown_req)); // R8
endmodule

// File: rtl/wdt_core.sv
// Module: wdt_core
// Watchdog top: registers, prescaler and countdown wired together.
// Assumes the register port issues single-cycle write strobes and reads
// combinationally. Expiry drives a one-clock reset or shutdown request.
module wdt_core
    import wdt_pkg::*;
#(
    parameter int unsigned ADDR_W    = 3,
    parameter int unsigned CTRL_OFF  = 0,
    parameter int unsigned COUNT_OFF = 4,
    parameter int unsigned DIV_0     = 2,
    parameter int unsigned DIV_1     = 3,
    parameter int unsigned DIV_2     = 5,
    parameter int unsigned DIV_3     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              hw_disable,
    input  logic [1:0]        tick_sel,
    output logic              reset_req,
    output logic              shutdown_req
);
    logic run;
    logic fired;
    logic sd_sel;
    logic restart;
    logic tick;
    logic expire;
    logic [TMO_W-1:0] timeout;

    wdt_regs #(
        .ADDR_W    (ADDR_W),
        .CTRL_OFF  (CTRL_OFF),
        .COUNT_OFF (COUNT_OFF)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .hw_disable (hw_disable),
        .expire     (expire),
        .reg_rdata  (reg_rdata),
        .run        (run),
        .fired      (fired),
        .sd_sel     (sd_sel),
        .restart    (restart),
        .timeout    (timeout)
    );

    wdt_prescaler #(
        .DIV_0 (DIV_0),
        .DIV_1 (DIV_1),
        .DIV_2 (DIV_2),
        .DIV_3 (DIV_3)
    ) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (restart),
        .sel     (tick_sel),
        .tick    (tick)
    );

    wdt_countdown u_count (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (restart),
        .load_val     (timeout),
        .tick         (tick),
        .sd_sel       (sd_sel),
        .expire       (expire),
        .reset_req    (reset_req),
        .shutdown_req (shutdown_req)
    );

    AST_EXPIRY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req || shutdown_req) |-> (fired && !run)); // R8
endmodule

// File: tb/test_wdt_core.sv
module test_wdt_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        hw_disable = 1'b0;
    logic [1:0]  tick_sel = '0;
    logic        reset_req;
    logic        shutdown_req;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit live = 0;
    int divs [4] = '{2, 3, 5, 8};

    always #5 clk = ~clk;

    wdt_core i_wdt_core (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_disable(hw_disable),
        .tick_sel(tick_sel), .reset_req(reset_req), .shutdown_req(shutdown_req)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on each rising edge.
    int m_run = 0, m_fired = 0, m_sdsel = 0, m_tmo = 0, m_cnt = 0, m_pc = 0;
    int m_prst = 0, m_psd = 0;
    always @(posedge clk) begin : model
        int div, restart, tick, ctrlw, old_run, old_sd;
        if (!rst_n) begin
            m_run = 0; m_fired = 0; m_sdsel = 0; m_tmo = 0; m_cnt = 0; m_pc = 0;
            m_prst = 0; m_psd = 0;
        end else begin
            div = divs[tick_sel];
            ctrlw = (reg_wr && reg_addr == 0) ? 1 : 0;
            old_run = m_run; old_sd = m_sdsel;
            restart = (ctrlw && (reg_wdata[7] || (reg_wdata[0] && !old_run && !hw_disable))) ? 1 : 0;
            tick = (old_run && !restart && m_pc >= div - 1) ? 1 : 0;
            m_prst = 0; m_psd = 0;
            if (restart || !old_run || m_pc >= div - 1) m_pc = 0; else m_pc++;
            if (ctrlw) begin
                m_run = (reg_wdata[0] && !hw_disable) ? 1 : 0;
                if (reg_wdata[1]) m_fired = 0;
                m_sdsel = reg_wdata[2];
            end else if (hw_disable) m_run = 0;
            if (reg_wr && reg_addr == 4) m_tmo = int'(reg_wdata[15:0]);
            if (restart) m_cnt = m_tmo;
            if (tick) begin
                if (m_cnt <= 1) begin
                    m_cnt = 0; m_run = 0; m_fired = 1;
                    if (old_sd) m_psd = 1; else m_prst = 1;
                end else m_cnt--;
            end
        end
    end

    // Every-cycle comparison against the model, away from the edge.
    always @(negedge clk) begin
        if (live) begin
            longint exp_rd;
            #1;
            exp_rd = 0;
            if (reg_addr == 0) exp_rd = m_run | (m_fired << 1) | (m_sdsel << 2) | (hw_disable << 3);
            else if (reg_addr == 4) exp_rd = m_tmo;
            check(reg_addr == 0 ? "R2" : "R3", "model read", reg_rdata, exp_rd);
            check("R8", "model reset_req", reset_req, m_prst);
            check("R8", "model shutdown_req", shutdown_req, m_psd);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected <= 50000 cycles", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk); reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk); reg_addr = a; #2; v = reg_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_exp(input int limit, output int n, output int got_r, output int got_s);
        n = 0; got_r = 0; got_s = 0;
        while (n < limit && !got_r && !got_s) begin
            @(negedge clk); #1; n++;
            got_r = reset_req; got_s = shutdown_req;
        end
    endtask

    initial begin
        logic [31:0] v;
        int n, gr, gs;
        idle(3);
        rst_n = 1'b1;
        live = 1;
        // R1 reset state
        rd(0, v); check("R1", "ctrl after reset", v, 0);
        rd(4, v); check("R1", "count after reset", v, 0);
        check("R1", "requests after reset", {reset_req, shutdown_req}, 0);
        // R3 timeout register and unmapped offset
        wr(4, 32'hABCD_0003); rd(4, v); check("R3", "count readback", v, 32'h3);
        wr(2, 32'hFFFF_FFFF); rd(2, v); check("R3", "unmapped read", v, 0);
        rd(0, v); check("R3", "unmapped write ignored", v, 0);
        // R4 R5 R8: ratio 2, timeout 3 -> 6 clocks, reset request
        tick_sel = 2'd0;
        wr(0, 32'h1);
        wait_exp(100, n, gr, gs);
        check("R5", "expiry distance sel0 N3", n, 6);
        check("R8", "reset request chosen", gr, 1);
        rd(0, v); check("R8", "fired set run clear", v, 32'h2);
        // R9 write-one-to-clear
        wr(0, 32'h0); rd(0, v); check("R9", "write 0 keeps fired", v, 32'h2);
        wr(0, 32'h2); rd(0, v); check("R9", "write 1 clears fired", v, 32'h0);
        // R5 R4: timeout 0 with ratio 3 -> 3 clocks
        tick_sel = 2'd1;
        wr(4, 32'h0); wr(0, 32'h1);
        wait_exp(100, n, gr, gs);
        check("R5", "expiry distance N0 sel1", n, 3);
        // R4 ratio 5, timeout 2 -> 10
        tick_sel = 2'd2;
        wr(4, 32'h2); wr(0, 32'h1);
        wait_exp(100, n, gr, gs);
        check("R4", "expiry distance sel2 N2", n, 10);
        // R8 shutdown: ratio 8, timeout 2 -> 16
        tick_sel = 2'd3;
        wr(0, 32'h5);
        wait_exp(100, n, gr, gs);
        check("R4", "expiry distance sel3 N2", n, 16);
        check("R8", "shutdown chosen", gs, 1);
        check("R8", "no reset with shutdown", gr, 0);
        // R6 reload pushes expiry out
        tick_sel = 2'd0;
        wr(0, 32'h2); wr(4, 32'h4); wr(0, 32'h1);
        idle(5);
        wr(0, 32'h81);
        wait_exp(100, n, gr, gs);
        check("R6", "expiry after reload", n, 8);
        rd(0, v); check("R6", "reload bit reads 0", v[7], 0);
        // R7 pause and resume
        wr(0, 32'h2); wr(4, 32'h5); wr(0, 32'h1);
        idle(4);
        wr(0, 32'h0);
        wait_exp(40, n, gr, gs);
        check("R7", "no request while paused", gr | gs, 0);
        rd(0, v); check("R7", "run reads 0 when paused", v, 0);
        wr(0, 32'h1);
        wait_exp(100, n, gr, gs);
        check("R7", "resume reloads full timeout", n, 10);
        // R11 collision: control write without reload on the expiry edge
        wr(4, 32'h1);
        wr(0, 32'h1);
        wr(0, 32'h3);
        #1; check("R11", "request on collision edge", reset_req, 1);
        rd(0, v); check("R11", "expiry wins over write", v, 32'h2);
        // R10 hardware disable
        wr(0, 32'h2);
        hw_disable = 1'b1;
        wr(0, 32'h1); rd(0, v); check("R10", "run ignored when disabled", v, 32'h8);
        wait_exp(40, n, gr, gs);
        check("R10", "no request when disabled", gr | gs, 0);
        hw_disable = 1'b0;
        wr(4, 32'hA); wr(0, 32'h1);
        idle(3);
        hw_disable = 1'b1;
        idle(2);
        rd(0, v); check("R10", "disable stops running timer", v, 32'h8);
        wait_exp(40, n, gr, gs);
        check("R10", "stopped timer stays quiet", gr | gs, 0);
        hw_disable = 1'b0;
        idle(2);
        live = 0;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule